// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block produces one high pulse on its output for every accepted trigger. A 16-bit counter counts down on a tick taken from an internal divider of the system clock. The pulse lasts as many tick periods as the counter held when the trigger came. When the count finishes, the output drops and the counter refills from a reload register. A single-cycle interrupt request marks the end of each pulse.

A mode byte sets three things: which trigger source is used, which edge of the external input counts as a trigger, and which tick rate drives the counter. There are two trigger sources, a one-cycle software strobe or an edge on the external input. A trigger that arrives while a pulse is running restarts the count from the reload value, which stretches the pulse. This restart is only honoured once the count has been running long enough, as set out in R10.

A count-enable input gates the whole timer. The interface has no streamed data, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. Register writes are single-cycle strobes with data.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the pulse output is low, the interrupt request is low, and the counter, the reload register and the mode byte are all zero.
- R2: A reload write while no pulse is running loads both the reload register and the counter. A reload write during a pulse changes only the reload register, and the counter picks up the new value when the pulse ends.
- R3: Mode bits 7:6 select the count tick as the system clock divided by 2, 16, 64 or 512, for codes 00, 01, 10 and 11 in that order. A pulse started from a count of N lasts between (N-1)*D+1 and N*D system cycles, where D is the divide ratio.
- R4: With mode bit 4 at 0, only the software strobe triggers the timer, and edges on the external input have no effect.
- R5: With mode bit 4 at 1, the external input triggers the timer after a two-flop synchronizer. Mode bit 3 picks the edge: 0 for falling, 1 for rising. The software strobe has no effect in this mode.
- R6: While enable is 0, triggers are ignored and the pulse output is low in the same cycle that enable falls. The counter keeps its value.
- R7: An accepted trigger with a nonzero counter drives the output high on the next clock edge. The counter then decrements once per tick.
- R8: A tick that finds the counter at 1 does three things in one cycle: it drives the output low, copies the reload register into the counter, and raises a one-cycle interrupt request.
- R9: A trigger while the counter holds zero produces no pulse and no interrupt.
- R10: A trigger during a pulse reloads the counter, but only if at least two ticks have passed since the previous accepted trigger. An earlier trigger is ignored.
- R11: A trigger while idle does not reload the counter. Counting starts from whatever value the counter holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_data | input | 8 | Mode byte: [7:6] tick select, [4] external source, [3] rising edge |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_data | input | 16 | Reload value |
| enable | input | 1 | Count enable; low forces the output low |
| sw_start | input | 1 | One-cycle software trigger strobe |
| trig_in | input | 1 | Asynchronous external trigger input |
| pulse_out | output | 1 | One-shot pulse output |
| irq | output | 1 | One-cycle interrupt request at pulse end |
| cnt_value | output | 16 | Current counter value |

## Verification
The assertions assume that a reload write never falls in the same cycle as a trigger, so a pulse never starts from a value written in that cycle. They also assume the mode byte changes only while the timer is idle. The stimulus keeps these apart by finishing every register write before it strobes or toggles a trigger, and by waiting for the output to fall before writing a new mode. Retriggers are placed both inside and outside the two-tick window so that both outcomes of R10 occur.

// File: rtl/ost_pkg.sv
package ost_pkg;
  // Mode byte layout; the field positions are decoded by the timer.
  typedef struct packed {
    logic [1:0] tick_sel;   // [7:6]
    logic       spare_hi;   // [5]
    logic       ext_src;    // [4]
    logic       rise_edge;  // [3]
    logic [2:0] spare_lo;   // [2:0]
  } mode_t;

  localparam int NUM_RATES = 4;

  // log2 of the divide ratio for each tick select code
  function automatic int rate_log2(input int code);
    case (code)
      0:       return 1;
      1:       return 4;
      2:       return 6;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/ost_prescaler.sv
module ost_prescaler #(
  parameter int PW = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PW-1:0]                  div_q;
  logic [ost_pkg::NUM_RATES-1:0]  hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < ost_pkg::NUM_RATES; i++) begin : g_rate
    localparam int L = ost_pkg::rate_log2(i);
    assign hit[i] = &div_q[L-1:0];
  end

  assign tick = hit[sel];
endmodule

// File: rtl/ost_trigger.sv
module ost_trigger #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic sw_start,
  input  logic ext_src,
  input  logic rise_edge,
  output logic trig
);
  logic [SYNC:0] sh_q;
  logic          rise, fall, ext_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], trig_in};
  end

  assign rise    =  sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall    = ~sh_q[SYNC-1] &  sh_q[SYNC];
  assign ext_hit = rise_edge ? rise : fall;
  assign trig    = ext_src ? ext_hit : sw_start;
endmodule

// File: rtl/ost_core.sv
module ost_core #(
  parameter int CW           = 16,
  parameter int RETRIG_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          trig,
  input  logic          tick,
  input  logic          reload_we,
  input  logic [CW-1:0] reload_data,
  output logic          run,
  output logic          irq,
  output logic [CW-1:0] cnt
);
  localparam int SW = $clog2(RETRIG_TICKS + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, rel_q;
  logic [SW-1:0] since_q;
  logic          run_q, irq_q, retrig_ok;

  assign retrig_ok = (since_q >= SW'(RETRIG_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rel_q   <= '0;
      since_q <= '0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!enable) begin
        run_q <= 1'b0;
      end else if (trig && !run_q) begin
        if (cnt_q != '0) begin
          run_q   <= 1'b1;
          since_q <= '0;
        end
      end else if (trig && retrig_ok) begin
        cnt_q   <= rel_q;
        since_q <= '0;
      end else if (run_q && tick) begin
        if (cnt_q == ONE) begin
          run_q <= 1'b0;
          cnt_q <= rel_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (!retrig_ok) since_q <= since_q + 1'b1;
        end
      end
      if (reload_we) begin
        rel_q <= reload_data;
        if (!run_q) cnt_q <= reload_data;
      end
    end
  end

  assign run = run_q;
  assign irq = irq_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CW           = 16,
  parameter int SYNC         = 2,
  parameter int RETRIG_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [7:0]    mode_data,
  input  logic          reload_we,
  input  logic [CW-1:0] reload_data,
  input  logic          enable,
  input  logic          sw_start,
  input  logic          trig_in,
  output logic          pulse_out,
  output logic          irq,
  output logic [CW-1:0] cnt_value
);
  localparam int PW = ost_pkg::rate_log2(ost_pkg::NUM_RATES - 1);

  ost_pkg::mode_t mode_q;
  logic           tick, trig, run;
  logic           unused_spare;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= ost_pkg::mode_t'(mode_data);
  end

  assign unused_spare = ^{mode_q.spare_hi, mode_q.spare_lo};

  ost_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(mode_q.tick_sel), .tick(tick)
  );

  ost_trigger #(.SYNC(SYNC)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sw_start(sw_start),
    .ext_src(mode_q.ext_src), .rise_edge(mode_q.rise_edge), .trig(trig)
  );

  ost_core #(.CW(CW), .RETRIG_TICKS(RETRIG_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig), .tick(tick),
    .reload_we(reload_we), .reload_data(reload_data),
    .run(run), .irq(irq), .cnt(cnt_value)
  );

  assign pulse_out = run & enable;
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          reload_we,
  input logic          pulse_out,
  input logic          irq,
  input logic [CW-1:0] cnt_value
);
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_ends_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(pulse_out) && !pulse_out));

  p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pulse_out);

  p_zero_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> (cnt_value != '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pulse_out) && !pulse_out && $past(enable) && enable && !$past(reload_we))
      |-> $stable(cnt_value));
endmodule

bind oneshot_timer ost_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .reload_we(reload_we),
  .pulse_out(pulse_out), .irq(irq), .cnt_value(cnt_value)
);

// File: tb/tb_oneshot_timer.sv
module tb_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_data = '0;
  logic        reload_we = 1'b0;
  logic [15:0] reload_data = '0;
  logic        enable = 1'b0;
  logic        sw_start = 1'b0;
  logic        trig_in = 1'b0;
  logic        pulse_out, irq;
  logic [15:0] cnt_value;

  always #4 clk = ~clk;

  oneshot_timer dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_data(mode_data),
    .reload_we(reload_we), .reload_data(reload_data), .enable(enable),
    .sw_start(sw_start), .trig_in(trig_in), .pulse_out(pulse_out),
    .irq(irq), .cnt_value(cnt_value)
  );

  int    checks = 0, errors = 0, irq_seen = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int  m_cnt, m_rel, m_since, pc;
  bit  m_run, m_irq;
  bit [7:0] m_mode;
  bit  h[$];

  always @(posedge clk) begin : model
    int  d, n_cnt, n_since;
    bit  tk, s2, s3, edg, trg, n_run;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_since = 0; pc = 0;
      m_run = 0; m_irq = 0; m_mode = 0;
      h = '{0, 0, 0};
    end else begin
      d  = 2 ** ((m_mode[7:6] == 0) ? 1 : (m_mode[7:6] == 1) ? 4 : (m_mode[7:6] == 2) ? 6 : 9);
      tk = (pc % d) == d - 1;
      pc++;
      s2 = h[1]; s3 = h[2];
      edg = m_mode[3] ? (s2 && !s3) : (!s2 && s3);
      trg = m_mode[4] ? edg : sw_start;
      n_cnt = m_cnt; n_run = m_run; n_since = m_since;
      m_irq = 0;
      if (!enable) n_run = 0;
      else if (trg && !m_run) begin
        if (m_cnt != 0) begin n_run = 1; n_since = 0; end
      end else if (trg && m_since >= 2) begin
        n_cnt = m_rel; n_since = 0;
      end else if (m_run && tk) begin
        if (m_cnt == 1) begin n_run = 0; n_cnt = m_rel; m_irq = 1; end
        else begin n_cnt = m_cnt - 1; if (m_since < 2) n_since = m_since + 1; end
      end
      if (reload_we) begin
        if (!m_run) n_cnt = reload_data;
        m_rel = reload_data;
      end
      if (mode_we) m_mode = mode_data;
      m_cnt = n_cnt; m_run = n_run; m_since = n_since;
      h.push_front(trig_in);
      void'(h.pop_back());
    end
  end

  // Per-clock comparison, well after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(cur_req, "pulse_out vs model", pulse_out, int'(m_run && enable));
      chk(cur_req, "irq vs model", irq, int'(m_irq));
      chk(cur_req, "cnt_value vs model", cnt_value, m_cnt);
      if (irq) irq_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(bit [7:0] v);
    @(negedge clk); mode_we = 1; mode_data = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_rel(int v);
    @(negedge clk); reload_we = 1; reload_data = 16'(v);
    @(negedge clk); reload_we = 0;
  endtask

  task automatic strobe();
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic measure(output int w);
    w = 0;
    while (pulse_out && w < 5000) begin w++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    int k = 0;
    while (pulse_out && k < 5000) begin k++; @(negedge clk); end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int w, v, base;
    cyc(3);
    cur_req = "R1";
    chk("R1", "reset pulse_out", pulse_out, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset cnt_value", cnt_value, 0);
    rst_n = 1;
    cyc(2);

    cur_req = "R2";
    wr_mode(8'h00);
    wr_rel(5);
    chk("R2", "idle reload write loads counter", cnt_value, 5);

    cur_req = "R7";
    enable = 1;
    base = irq_seen;
    strobe();
    chk("R7", "output high after trigger", pulse_out, 1);
    measure(w);
    chk_range("R7", "pulse width N=5 div2", w, 9, 10);
    cyc(2);
    chk("R8", "one irq per pulse", irq_seen - base, 1);
    chk("R8", "counter reloaded at end", cnt_value, 5);

    cur_req = "R3";
    for (int c = 0; c < 4; c++) begin
      int dv;
      dv = (c == 0) ? 2 : (c == 1) ? 16 : (c == 2) ? 64 : 512;
      wr_mode(8'(c << 6));
      wr_rel(3);
      strobe();
      measure(w);
      chk_range("R3", "pulse width N=3", w, 2 * dv + 1, 3 * dv);
      cyc(2);
    end

    cur_req = "R4";
    wr_mode(8'h00);
    wr_rel(4);
    trig_in = 1; cyc(4); trig_in = 0; cyc(4);
    chk("R4", "external edge ignored in software mode", pulse_out, 0);

    cur_req = "R5";
    wr_mode(8'h18);
    strobe(); cyc(3);
    chk("R5", "software strobe ignored in external mode", pulse_out, 0);
    @(negedge clk); trig_in = 1; cyc(4);
    chk("R5", "rising edge triggers", pulse_out, 1);
    wait_idle(); cyc(2);
    @(negedge clk); trig_in = 0; cyc(5);
    chk("R5", "falling edge ignored in rising mode", pulse_out, 0);
    wr_mode(8'h10);
    @(negedge clk); trig_in = 1; cyc(5);
    chk("R5", "rising edge ignored in falling mode", pulse_out, 0);
    @(negedge clk); trig_in = 0; cyc(4);
    chk("R5", "falling edge triggers", pulse_out, 1);
    wait_idle(); cyc(2);

    cur_req = "R6";
    wr_mode(8'h00);
    wr_rel(20);
    strobe(); cyc(6);
    @(negedge clk); enable = 0; #1;
    chk("R6", "output low as soon as enable falls", pulse_out, 0);
    cyc(1);
    v = cnt_value;
    strobe(); cyc(3);
    chk("R6", "trigger ignored while disabled", pulse_out, 0);
    chk("R6", "counter held while disabled", cnt_value, v);

    cur_req = "R11";
    @(negedge clk); enable = 1;
    strobe();
    chk("R11", "idle trigger starts pulse", pulse_out, 1);
    chk_range("R11", "count continues from held value", cnt_value, 1, v);
    wait_idle(); cyc(2);
    chk("R11", "reload after resumed pulse", cnt_value, 20);

    cur_req = "R9";
    wr_rel(0);
    base = irq_seen;
    strobe(); cyc(4);
    chk("R9", "zero count gives no pulse", pulse_out, 0);
    chk("R9", "zero count gives no irq", irq_seen - base, 0);

    cur_req = "R10";
    wr_rel(30);
    strobe(); strobe();
    cyc(12);
    chk_range("R10", "early retrigger ignored", cnt_value, 20, 27);
    strobe();
    chk("R10", "late retrigger reloads", cnt_value, 30);

    cur_req = "R2";
    cyc(3);
    wr_rel(7);
    chk_range("R2", "running write leaves counter", cnt_value, 8, 30);
    wait_idle(); cyc(2);
    chk("R2", "new reload value used at end", cnt_value, 7);

    cyc(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule